// File: doc/BRIEF.md
# Drive Head Position and Media-Change Tracker

This block keeps the controller's view of a single drive: which cylinder the head is over, how it gets to a new one, and whether the medium may have been swapped since the head last moved. A command sequencer hands it seek requests. A request is either an absolute target cylinder, or a signed relative move given as a count plus a direction. The block walks the head there one cylinder at a time. It emits one step pulse per cylinder crossed, spaced by a fixed number of clock cycles. When the head arrives it raises a one-cycle completion strobe, and the sequencer can then take the final cylinder for its sense-interrupt result.

The media-change flag is a latch. It is forced high whenever the medium is absent and falls only when a real step pulse is issued while a medium is present. Looking at the flag does not disturb it. A seek that ends where the head already is issues no step, so it leaves the flag alone too. Relative moves saturate at cylinder 0 and at the highest cylinder the parameters allow. Absolute targets beyond that cylinder are clamped to it.

Top module: `drive_track_keeper`

## Requirements
- R1: After reset the present cylinder is 0, the media-change flag is 1, and busy, step_pulse and seek_done are all 0.
- R2: While media_present is 0 the media-change flag stays 1 through any number of observations and any seek, including seeks that issue step pulses.
- R3: A seek whose target equals the present cylinder issues no step pulse and leaves the media-change flag unchanged.
- R4: With media present, a seek to a different cylinder issues exactly one step pulse per cylinder crossed, and the media-change flag reads 0 from the first step onward.
- R5: Dropping media_present sets the media-change flag on the next clock edge. Raising media_present again does not clear the flag; only a later step pulse does.
- R6: An absolute seek (seek_mode 2'b00 or 2'b11) to a cylinder above MAX_CYL moves the head to MAX_CYL.
- R7: An inward relative seek (seek_mode 2'b01) adds seek_arg to the present cylinder, saturating at MAX_CYL.
- R8: An outward relative seek (seek_mode 2'b10) subtracts seek_arg from the present cylinder, saturating at 0.
- R9: The first step pulse comes STEP_CYCLES clock edges after the edge that accepts the request, and later steps follow every STEP_CYCLES edges. step_dir is 1 for a move to a higher cylinder and 0 for a move to a lower one.
- R10: seek_done is a one-cycle pulse on the edge after the last step, or on the edge after acceptance when no step is needed. When it pulses, busy is already 0 and cur_cyl holds the final cylinder.
- R11: A seek_req that arrives while busy is 1 is ignored: the running seek keeps its target and its step count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| media_present | input | 1 | High while a medium is in the drive |
| seek_req | input | 1 | One-cycle request to start a seek |
| seek_mode | input | 2 | 00/11 absolute, 01 relative inward, 10 relative outward |
| seek_arg | input | CYL_W | Target cylinder or relative step count |
| cur_cyl | output | CYL_W | Present cylinder number |
| busy | output | 1 | A seek is in progress |
| step_pulse | output | 1 | One-cycle step pulse, one per cylinder crossed |
| step_dir | output | 1 | Direction of the latest step, 1 = toward higher cylinders |
| seek_done | output | 1 | One-cycle seek completion strobe |
| disk_changed | output | 1 | Media-change latch |

## Verification
The seek engine is driven with absolute moves in both directions, with a zero-distance move, and with relative moves that stay in range or overflow either end. Together these separate step counting from target arithmetic and from saturation. The zero-distance move, run once with media present, shows that the flag clears only because of a step pulse and not because a seek completed. Moves made with the medium absent show that stepping alone does not clear the flag. The exact cycle of every step and of the completion strobe is checked, which exposes off-by-one errors in the interval timer. A request injected in the middle of a seek checks that a running seek cannot be retargeted.

// File: rtl/drive_track_keeper.sv
module drive_track_keeper #(
  parameter int CYL_W       = 8,
  parameter int MAX_CYL     = 79,
  parameter int STEP_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             media_present,
  input  logic             seek_req,
  input  logic [1:0]       seek_mode,
  input  logic [CYL_W-1:0] seek_arg,
  output logic [CYL_W-1:0] cur_cyl,
  output logic             busy,
  output logic             step_pulse,
  output logic             step_dir,
  output logic             seek_done,
  output logic             disk_changed
);

  localparam int TW = $clog2(STEP_CYCLES + 1);
  localparam logic [CYL_W-1:0] MAXC    = CYL_W'(MAX_CYL);
  localparam logic [TW-1:0]    TMR_END = TW'(STEP_CYCLES - 1);

  logic [CYL_W-1:0] tgt;
  logic [TW-1:0]    tmr;
  logic [CYL_W-1:0] next_tgt;
  logic [CYL_W:0]   up_sum;
  logic             take_req;
  logic             at_tgt;
  logic             do_step;

  assign up_sum   = {1'b0, cur_cyl} + {1'b0, seek_arg};
  assign take_req = seek_req && !busy;
  assign at_tgt   = (cur_cyl == tgt);
  assign do_step  = busy && !at_tgt && (tmr == TMR_END);

  always_comb begin
    case (seek_mode)
      2'b01:   next_tgt = (up_sum > {1'b0, MAXC}) ? MAXC : up_sum[CYL_W-1:0];
      2'b10:   next_tgt = (seek_arg >= cur_cyl) ? '0 : cur_cyl - seek_arg;
      default: next_tgt = (seek_arg > MAXC) ? MAXC : seek_arg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_cyl    <= '0;
      tgt        <= '0;
      tmr        <= '0;
      busy       <= 1'b0;
      step_pulse <= 1'b0;
      step_dir   <= 1'b0;
      seek_done  <= 1'b0;
    end else begin
      step_pulse <= 1'b0;
      seek_done  <= 1'b0;
      if (take_req) begin
        busy <= 1'b1;
        tgt  <= next_tgt;
        tmr  <= '0;
      end else if (busy) begin
        if (at_tgt) begin
          busy      <= 1'b0;
          seek_done <= 1'b1;
        end else if (do_step) begin
          step_pulse <= 1'b1;
          step_dir   <= (tgt > cur_cyl);
          cur_cyl    <= (tgt > cur_cyl) ? cur_cyl + 1'b1 : cur_cyl - 1'b1;
          tmr        <= '0;
        end else begin
          tmr <= tmr + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              disk_changed <= 1'b1;
    else if (!media_present) disk_changed <= 1'b1;
    else if (do_step)        disk_changed <= 1'b0;
  end

  p_cyl_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cur_cyl <= MAXC);

  p_absent_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !media_present |=> disk_changed);

  p_flag_falls_on_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(disk_changed) |-> step_pulse && $past(media_present));

  p_step_moves_head_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |-> cur_cyl != $past(cur_cyl));

  p_head_still_without_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !step_pulse |-> $stable(cur_cyl));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seek_done |-> !busy && !step_pulse);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seek_done |=> !seek_done);

endmodule

// File: tb/test_drive_track_keeper.sv
module test_drive_track_keeper;
  localparam int CYL_W = 8;
  localparam int MAXC  = 79;
  localparam int S     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic media_present = 1'b0;
  logic seek_req = 1'b0;
  logic [1:0] seek_mode = 2'b00;
  logic [CYL_W-1:0] seek_arg = '0;
  logic [CYL_W-1:0] cur_cyl;
  logic busy, step_pulse, step_dir, seek_done, disk_changed;

  int tests = 0;
  int fails = 0;
  int intrude_arg = -1;
  bit flag_first_step;
  bit flag_ever_low;

  always #4 clk = ~clk;

  drive_track_keeper #(.CYL_W(CYL_W), .MAX_CYL(MAXC), .STEP_CYCLES(S)) i_drive_track_keeper (
    .clk(clk), .rst_n(rst_n), .media_present(media_present), .seek_req(seek_req),
    .seek_mode(seek_mode), .seek_arg(seek_arg), .cur_cyl(cur_cyl), .busy(busy),
    .step_pulse(step_pulse), .step_dir(step_dir), .seek_done(seek_done),
    .disk_changed(disk_changed));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_seek(input logic [1:0] mode, input int arg, input int exp_cyl,
                         input int exp_steps, input bit exp_dir, input string req);
    int cyc = 0, nst = 0, last = 0, done_cyc = 0;
    bit gaps_ok = 1, dir_ok = 1;
    flag_first_step = 1'b1;
    flag_ever_low = 1'b0;
    @(negedge clk);
    seek_req = 1'b1; seek_mode = mode; seek_arg = CYL_W'(arg);
    while (done_cyc == 0 && cyc < 1500) begin
      @(negedge clk);
      cyc++;
      seek_req = 1'b0;
      if (intrude_arg >= 0 && cyc == 2) begin
        seek_req = 1'b1; seek_mode = 2'b00; seek_arg = CYL_W'(intrude_arg);
      end
      if (!disk_changed) flag_ever_low = 1'b1;
      if (step_pulse) begin
        if (cyc - last != ((nst == 0) ? S + 1 : S)) gaps_ok = 0;
        if (step_dir != exp_dir) dir_ok = 0;
        if (nst == 0) flag_first_step = disk_changed;
        nst++;
        last = cyc;
      end
      if (seek_done) begin
        done_cyc = cyc;
        chk(!busy, {req, " R10 busy low at done"}, busy, 0);
      end
    end
    seek_req = 1'b0;
    chk(int'(cur_cyl) == exp_cyl, {req, " final cylinder"}, cur_cyl, exp_cyl);
    chk(nst == exp_steps, {req, " R4 step count"}, nst, exp_steps);
    chk(done_cyc == ((exp_steps == 0) ? 2 : exp_steps * S + 2), {req, " R10 done timing"},
        done_cyc, (exp_steps == 0) ? 2 : exp_steps * S + 2);
    if (exp_steps > 0) begin
      chk(gaps_ok, {req, " R9 step spacing"}, gaps_ok, 1);
      chk(dir_ok, {req, " R9 step direction"}, dir_ok, 1);
    end
    @(negedge clk);
    chk(!seek_done, {req, " R10 done single cycle"}, seek_done, 0);
  endtask

  task automatic t_reset;
    chk(cur_cyl == 0, "R1 cylinder", cur_cyl, 0);
    chk(disk_changed == 1, "R1 flag", disk_changed, 1);
    chk(!busy && !step_pulse && !seek_done, "R1 strobes idle", {busy, step_pulse, seek_done}, 0);
  endtask

  task automatic t_no_media;
    repeat (3) begin
      @(negedge clk);
      chk(disk_changed == 1, "R2 flag held on repeated reads", disk_changed, 1);
    end
    do_seek(2'b00, 5, 5, 5, 1'b1, "R2 stepping seek without media");
    chk(!flag_ever_low, "R2 flag never dropped", flag_ever_low, 0);
    do_seek(2'b00, 0, 0, 5, 1'b0, "R2 return seek without media");
    chk(!flag_ever_low, "R2 flag never dropped on return", flag_ever_low, 0);
  endtask

  task automatic t_insert;
    media_present = 1'b1;
    repeat (2) @(negedge clk);
    chk(disk_changed == 1, "R5 insert keeps flag", disk_changed, 1);
    do_seek(2'b00, 0, 0, 0, 1'b0, "R3 seek to present cylinder");
    chk(disk_changed == 1, "R3 flag left set", disk_changed, 1);
    do_seek(2'b00, 3, 3, 3, 1'b1, "R4 seek inward with media");
    chk(flag_first_step == 0, "R4 flag clear at first step", flag_first_step, 0);
    chk(disk_changed == 0, "R4 flag clear after seek", disk_changed, 0);
  endtask

  task automatic t_eject;
    media_present = 1'b0;
    @(negedge clk);
    chk(disk_changed == 1, "R5 eject sets flag next edge", disk_changed, 1);
    do_seek(2'b00, 1, 1, 2, 1'b0, "R2 stepping after eject");
    chk(!flag_ever_low, "R2 flag held after eject", flag_ever_low, 0);
    media_present = 1'b1;
    repeat (2) @(negedge clk);
    chk(disk_changed == 1, "R5 reinsert keeps flag", disk_changed, 1);
    do_seek(2'b00, 2, 2, 1, 1'b1, "R4 step after reinsert");
    chk(disk_changed == 0, "R4 flag cleared by step", disk_changed, 0);
  endtask

  task automatic t_relative;
    do_seek(2'b00, 10, 10, 8, 1'b1, "R6 absolute in range");
    do_seek(2'b01, 5, 15, 5, 1'b1, "R7 relative inward");
    do_seek(2'b10, 7, 8, 7, 1'b0, "R8 relative outward");
    do_seek(2'b10, 200, 0, 8, 1'b0, "R8 outward saturates at 0");
    do_seek(2'b01, 250, MAXC, MAXC, 1'b1, "R7 inward saturates at max");
  endtask

  task automatic t_clamp;
    do_seek(2'b00, 2, 2, MAXC - 2, 1'b0, "R6 move down");
    do_seek(2'b11, 200, MAXC, MAXC - 2, 1'b1, "R6 absolute clamp to max");
    do_seek(2'b00, 77, 77, 2, 1'b0, "R6 absolute below max");
  endtask

  task automatic t_busy;
    do_seek(2'b00, 0, 0, 77, 1'b0, "R11 setup");
    intrude_arg = 9;
    do_seek(2'b00, 4, 4, 4, 1'b1, "R11 request during seek ignored");
    intrude_arg = -1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_media();
    t_insert();
    t_eject();
    t_relative();
    t_clamp();
    t_busy();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule